// File: doc/BRIEF.md
# Outstanding Bus Transaction Tracker

This block keeps one controller's copy of the outstanding-transaction table on a split-transaction coherent bus. The bus hands each request that wins arbitration a small tag. Every controller on the bus writes that request into the slot numbered by the tag, so all copies of the table stay aligned. The slot keeps the block address, the command and the snoop state that this controller worked out for the request. A later response carries the same tag, reports what the slot holds and empties it, so the bus can give the tag out again.

The processor side searches the table by address before it issues a request. It is told to hold off when a pending transaction on the same block is incompatible with its own. When it wants to read a block that already has a read pending, it is instead offered the chance to join that read and take the response data as a grabber. The table also watches the bus slot just before this controller's own request. If that slot carried a conflicting request for the same block, the table cancels its own request locally so that the request can be reissued later. A small allocator reports the lowest free tag and whether the table is full.

Top module: `reqtrack_table`

## Requirements
- R1: After reset every slot is empty: `free_tag` is 0, `table_full` is 0, a response on any tag reports `rsp_hit`=0, and no processor lookup stalls or offers a grab.
- R2: A bus request with command read (code 0) or read-exclusive (code 1) is stored in the slot given by `breq_tag` at the clock edge. From the next cycle on, processor lookups match it, and a response on that tag reports `rsp_hit`=1 with the stored address and snoop state (codes I=0, S=1, E=2, M=3).
- R3: A bus request with command upgrade (code 2) or writeback (code 3) creates no slot. Afterwards no lookup of its address stalls and `free_tag` is unchanged.
- R4: A response on a tag empties that slot at the clock edge. A second response on the same tag then reports `rsp_hit`=0.
- R5: `free_tag` is the lowest-numbered empty slot, and `table_full` is 1 exactly when all NUM_TAGS (default 8) slots are occupied.
- R6: A processor lookup stalls (`cpu_stall`=1) when an occupied slot holds the same address and the two commands are not both reads. Lookups of other addresses do not stall.
- R7: A processor read that matches an occupied read slot gives `cpu_can_grab`=1 and `cpu_stall`=0.
- R8: Raising `cpu_join` with a grab-eligible lookup marks that slot as grabbed. Its response then gives `rsp_take`=1 and `rsp_assert_shared`=1. A slot for this controller's own read gives `rsp_take`=1 and `rsp_assert_shared`=0. A slot for another controller's request that was not joined gives `rsp_take`=0.
- R9: When this controller's own request (`breq_mine`=1) arrives in the cycle right after a request for the same address whose command is incompatible with it, `own_degrade` is 1 in that cycle and no slot is stored. If an idle cycle separates the two requests, or both requests are reads, nothing is degraded.
- R10: A new request and a response on different tags in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| breq_valid | input | 1 | A request occupies the bus request slot this cycle |
| breq_tag | input | TAG_W | Tag the bus gave the request |
| breq_addr | input | ADDR_W | Block address of the request |
| breq_cmd | input | 2 | Command: 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| breq_mine | input | 1 | The request was issued by this controller |
| breq_snoop | input | 2 | Local snoop state for the request |
| rsp_valid | input | 1 | A response is on the bus this cycle |
| rsp_tag | input | TAG_W | Tag carried by the response |
| cpu_valid | input | 1 | Processor-side lookup is active |
| cpu_addr | input | ADDR_W | Block address the processor wants |
| cpu_cmd | input | 2 | Command the processor would issue |
| cpu_join | input | 1 | Join a matching pending read as a grabber |
| free_tag | output | TAG_W | Lowest empty slot |
| table_full | output | 1 | All slots occupied |
| cpu_stall | output | 1 | Incompatible pending transaction on the block |
| cpu_can_grab | output | 1 | A pending read on the block may be joined |
| own_degrade | output | 1 | Own request cancelled because the previous slot conflicts |
| rsp_hit | output | 1 | The response tag matches an occupied slot |
| rsp_take | output | 1 | This controller must take the response data |
| rsp_assert_shared | output | 1 | This controller must raise the shared line |
| rsp_addr | output | ADDR_W | Address stored in the responding slot |
| rsp_snoop | output | 2 | Snoop state stored in the responding slot |

## Verification
Lookup, response and allocator outputs are combinational from the stored slots, so each one is valid in the same cycle as the inputs that drive it. Any change made by a bus request, a response or a join shows up from the first cycle after the clock edge that captures it. The degrade flag is special: it depends on the request captured one edge earlier, so it is valid during the own request's cycle. The bench drives inputs just after the falling edge and samples one nanosecond later. After a stored change it always moves past exactly one rising edge before it looks for the effect.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SNP_I = 2'd0,
        SNP_S = 2'd1,
        SNP_E = 2'd2,
        SNP_M = 2'd3
    } snp_e;

    // Only commands that expect a data response hold a slot.
    function automatic logic holds_slot(bus_cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDX);
    endfunction

    // Two transactions on one block may overlap only if both are reads.
    function automatic logic cmds_compatible(bus_cmd_e a, bus_cmd_e b);
        return (a == CMD_RD) && (b == CMD_RD);
    endfunction

endpackage

// File: rtl/rtt_alloc.sv
module rtt_alloc #(
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input  logic [NUM_TAGS-1:0] occ,
    output logic [TAG_W-1:0]    free_tag,
    output logic                full
);
    always_comb begin
        free_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!occ[i]) free_tag = TAG_W'(i);
        end
    end

    assign full = &occ;
endmodule

// File: rtl/rtt_match.sv
module rtt_match
    import rtt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 26
) (
    input  logic [NUM_TAGS-1:0]             occ,
    input  logic [NUM_TAGS-1:0][ADDR_W-1:0] tab_addr,
    input  logic [NUM_TAGS-1:0][1:0]        tab_cmd,
    input  logic                            key_valid,
    input  logic [ADDR_W-1:0]               key_addr,
    input  logic [1:0]                      key_cmd,
    output logic [NUM_TAGS-1:0]             hit,
    output logic                            conflict,
    output logic                            shareable
);
    logic [NUM_TAGS-1:0] bad;
    logic [NUM_TAGS-1:0] rd_hit;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cmp
        assign hit[g]    = key_valid && occ[g] && (tab_addr[g] == key_addr);
        assign bad[g]    = hit[g] &&
                           !cmds_compatible(bus_cmd_e'(tab_cmd[g]), bus_cmd_e'(key_cmd));
        assign rd_hit[g] = hit[g] && !bad[g];
    end

    assign conflict  = |bad;
    assign shareable = (|rd_hit) && !conflict;
endmodule

// File: rtl/rtt_slot_guard.sv
module rtt_slot_guard
    import rtt_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_cmd,
    input  logic              req_mine,
    output logic              degrade
);
    logic              prev_valid;
    logic [ADDR_W-1:0] prev_addr;
    bus_cmd_e          prev_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid <= 1'b0;
            prev_addr  <= '0;
            prev_cmd   <= CMD_RD;
        end else begin
            prev_valid <= req_valid;
            prev_addr  <= req_addr;
            prev_cmd   <= bus_cmd_e'(req_cmd);
        end
    end

    assign degrade = req_valid && req_mine && prev_valid &&
                     (prev_addr == req_addr) &&
                     !cmds_compatible(prev_cmd, bus_cmd_e'(req_cmd));
endmodule

// File: rtl/reqtrack_table.sv
module reqtrack_table
    import rtt_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int ADDR_W   = 26,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              breq_valid,
    input  logic [TAG_W-1:0]  breq_tag,
    input  logic [ADDR_W-1:0] breq_addr,
    input  logic [1:0]        breq_cmd,
    input  logic              breq_mine,
    input  logic [1:0]        breq_snoop,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_cmd,
    input  logic              cpu_join,
    output logic [TAG_W-1:0]  free_tag,
    output logic              table_full,
    output logic              cpu_stall,
    output logic              cpu_can_grab,
    output logic              own_degrade,
    output logic              rsp_hit,
    output logic              rsp_take,
    output logic              rsp_assert_shared,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_snoop
);
    logic [NUM_TAGS-1:0]             vld;
    logic [NUM_TAGS-1:0]             orig_q;
    logic [NUM_TAGS-1:0]             grab_q;
    logic [NUM_TAGS-1:0][ADDR_W-1:0] addr_q;
    logic [NUM_TAGS-1:0][1:0]        cmd_q;
    logic [NUM_TAGS-1:0][1:0]        snp_q;

    logic [NUM_TAGS-1:0] cpu_hit;
    logic                wr_en;
    logic                join_en;

    rtt_alloc #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_alloc (
        .occ      (vld),
        .free_tag (free_tag),
        .full     (table_full)
    );

    rtt_match #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W)) u_cpu_match (
        .occ       (vld),
        .tab_addr  (addr_q),
        .tab_cmd   (cmd_q),
        .key_valid (cpu_valid),
        .key_addr  (cpu_addr),
        .key_cmd   (cpu_cmd),
        .hit       (cpu_hit),
        .conflict  (cpu_stall),
        .shareable (cpu_can_grab)
    );

    rtt_slot_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .req_valid (breq_valid),
        .req_addr  (breq_addr),
        .req_cmd   (breq_cmd),
        .req_mine  (breq_mine),
        .degrade   (own_degrade)
    );

    assign wr_en   = breq_valid && holds_slot(bus_cmd_e'(breq_cmd)) && !own_degrade;
    assign join_en = cpu_join && cpu_can_grab;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld[g]    <= 1'b0;
                orig_q[g] <= 1'b0;
                grab_q[g] <= 1'b0;
                addr_q[g] <= '0;
                cmd_q[g]  <= CMD_RD;
                snp_q[g]  <= SNP_I;
            end else begin
                if (rsp_valid && rsp_tag == TAG_W'(g)) vld[g] <= 1'b0;
                if (wr_en && breq_tag == TAG_W'(g)) begin
                    vld[g]    <= 1'b1;
                    orig_q[g] <= breq_mine;
                    grab_q[g] <= 1'b0;
                    addr_q[g] <= breq_addr;
                    cmd_q[g]  <= breq_cmd;
                    snp_q[g]  <= breq_snoop;
                end else if (join_en && cpu_hit[g]) begin
                    grab_q[g] <= 1'b1;
                end
            end
        end
    end

    assign rsp_hit           = rsp_valid && vld[rsp_tag];
    assign rsp_take          = rsp_hit && (orig_q[rsp_tag] || grab_q[rsp_tag]);
    assign rsp_assert_shared = rsp_hit && grab_q[rsp_tag];
    assign rsp_addr          = addr_q[rsp_tag];
    assign rsp_snoop         = snp_q[rsp_tag];
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                breq_valid,
    input logic [TAG_W-1:0]    breq_tag,
    input logic [1:0]          breq_cmd,
    input logic                own_degrade,
    input logic                rsp_valid,
    input logic [TAG_W-1:0]    rsp_tag,
    input logic                cpu_stall,
    input logic                cpu_can_grab,
    input logic                table_full,
    input logic [TAG_W-1:0]    free_tag,
    input logic                rsp_take,
    input logic                rsp_assert_shared,
    input logic [NUM_TAGS-1:0] vld
);
    // R2
    store_chk: assert property (@(posedge clk) disable iff (rst)
        (breq_valid && !breq_cmd[1] && !own_degrade) |=> vld[$past(breq_tag)]);

    // R3
    no_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (breq_valid && breq_cmd[1] && !rsp_valid) |=> $stable(vld));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !(breq_valid && breq_tag == rsp_tag)) |=> !vld[$past(rsp_tag)]);

    // R5
    free_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !table_full |-> !vld[free_tag]);

    // R6
    stall_grab_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_stall && cpu_can_grab));

    // R8
    shared_take_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_assert_shared |-> rsp_take);

    // R9
    degrade_chk: assert property (@(posedge clk) disable iff (rst)
        (own_degrade && !vld[breq_tag]) |=> !vld[$past(breq_tag)]);
endmodule

bind reqtrack_table rtt_checker #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/reqtrack_table_test.sv
module reqtrack_table_test;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          breq_valid, breq_mine, rsp_valid, cpu_valid, cpu_join;
    logic [2:0]    breq_tag, rsp_tag, free_tag;
    logic [AW-1:0] breq_addr, cpu_addr, rsp_addr;
    logic [1:0]    breq_cmd, breq_snoop, cpu_cmd, rsp_snoop;
    logic          table_full, cpu_stall, cpu_can_grab, own_degrade;
    logic          rsp_hit, rsp_take, rsp_assert_shared;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    reqtrack_table uut (.*);

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        breq_valid = 0; breq_mine = 0; rsp_valid = 0; cpu_valid = 0; cpu_join = 0;
    endtask

    task automatic req(int tag, int addr, int cmd, bit mine, int snp);
        breq_valid = 1; breq_tag = 3'(tag); breq_addr = AW'(addr);
        breq_cmd = 2'(cmd); breq_mine = mine; breq_snoop = 2'(snp);
    endtask

    task automatic rsp(int tag);
        rsp_valid = 1; rsp_tag = 3'(tag);
    endtask

    task automatic look(int addr, int cmd);
        cpu_valid = 1; cpu_addr = AW'(addr); cpu_cmd = 2'(cmd);
    endtask

    task automatic t_reset();
        rsp(3); look('h55, 1); #1;
        chk("R1 free_tag", free_tag, 0);
        chk("R1 full", table_full, 0);
        chk("R1 rsp_hit", rsp_hit, 0);
        chk("R1 stall", cpu_stall, 0);
        chk("R1 grab", cpu_can_grab, 0);
        tick();
    endtask

    task automatic t_store();
        req(2, 'h100, 0, 0, 2); tick();
        look('h100, 0); #1;
        chk("R7 grab", cpu_can_grab, 1);
        chk("R7 stall", cpu_stall, 0);
        tick();
        rsp(2); #1;
        chk("R2 hit", rsp_hit, 1);
        chk("R2 addr", rsp_addr, 'h100);
        chk("R2 snoop", rsp_snoop, 2);
        chk("R8 foreign take", rsp_take, 0);
        tick();
        rsp(2); #1;
        chk("R4 freed", rsp_hit, 0);
        tick();
    endtask

    task automatic t_noslot();
        req(0, 'h200, 3, 0, 0); tick();
        req(0, 'h210, 2, 0, 1); tick();
        look('h200, 1); #1;
        chk("R3 wb no stall", cpu_stall, 0);
        chk("R3 free_tag", free_tag, 0);
        tick();
        look('h210, 1); #1;
        chk("R3 upgr no stall", cpu_stall, 0);
        tick();
    endtask

    task automatic t_conflict();
        req(0, 'h300, 1, 0, 0); tick();
        req(1, 'h400, 0, 0, 1); tick();
        look('h300, 0); #1;
        chk("R6 rd vs rdx", cpu_stall, 1);
        chk("R6 no grab", cpu_can_grab, 0);
        tick();
        look('h300, 1); #1; chk("R6 rdx vs rdx", cpu_stall, 1); tick();
        look('h304, 1); #1; chk("R6 other addr", cpu_stall, 0); tick();
        look('h400, 1); #1; chk("R6 rdx vs rd", cpu_stall, 1); tick();
        look('h400, 0); cpu_join = 1; #1;
        chk("R7 joinable", cpu_can_grab, 1);
        tick();
        rsp(1); #1;
        chk("R8 grab take", rsp_take, 1);
        chk("R8 grab shared", rsp_assert_shared, 1);
        tick();
        req(3, 'h500, 0, 1, 2); tick();
        rsp(3); #1;
        chk("R8 own take", rsp_take, 1);
        chk("R8 own shared", rsp_assert_shared, 0);
        tick();
        rsp(0); tick();
    endtask

    task automatic t_fill();
        for (int i = 0; i < 8; i++) begin
            #1 chk("R5 lowest free", free_tag, i);
            req(i, 'h1000 + i, 0, 0, 1); tick();
        end
        #1 chk("R5 full", table_full, 1);
        rsp(5); tick();
        #1 chk("R5 after free 5", free_tag, 5);
        chk("R5 not full", table_full, 0);
        rsp(2); tick();
        #1 chk("R5 after free 2", free_tag, 2);
        req(2, 'h2000, 1, 0, 0); rsp(6); tick();
        look('h2000, 0); #1;
        chk("R10 free_tag", free_tag, 5);
        chk("R10 new slot", cpu_stall, 1);
        tick();
        rsp(6); #1; chk("R10 rsp freed", rsp_hit, 0); tick();
        for (int i = 0; i < 8; i++) begin
            rsp(i); tick();
        end
        #1 chk("R4 drained", free_tag, 0);
    endtask

    task automatic t_degrade();
        req(0, 'h700, 1, 0, 0); tick();
        req(1, 'h700, 0, 1, 1); #1;
        chk("R9 adjacent conflict", own_degrade, 1);
        tick();
        rsp(1); #1; chk("R9 no slot", rsp_hit, 0); tick();
        req(4, 'h900, 1, 0, 0); tick();
        tick();
        req(5, 'h900, 1, 1, 0); #1;
        chk("R9 gap", own_degrade, 0);
        tick();
        req(6, 'hA00, 0, 0, 1); tick();
        req(7, 'hA00, 0, 1, 1); #1;
        chk("R9 both reads", own_degrade, 0);
        tick();
        rsp(5); #1; chk("R9 gap stored", rsp_hit, 1); tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; breq_valid = 0; breq_mine = 0; rsp_valid = 0; cpu_valid = 0; cpu_join = 0;
        breq_tag = 0; rsp_tag = 0; breq_addr = 0; cpu_addr = 0;
        breq_cmd = 0; breq_snoop = 0; cpu_cmd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_store();
        t_noslot();
        t_conflict();
        t_fill();
        t_degrade();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule